// File: doc/BRIEF.md
# Ramp Test Pattern Generator

This block sits on a 12-bit pixel output path and can stand in for the image sensor. In live mode the pixels from the sensor pass through unchanged. In either pattern mode the block makes its own pixels. Each pattern is a horizontal ramp that rises by one code per pixel and starts again at every line strobe. In the fixed pattern every line and every frame are the same. In the sliding pattern the whole ramp moves up by two codes on every new frame. The receiver can therefore see that frames are advancing before any image settings have been tuned.

The block is driven by a pixel-valid qualifier, a line-start strobe and a frame-start strobe. A strobe acts on the pixel presented in the same cycle. The output is registered, so every accepted pixel appears on the output one clock later together with a valid flag.

Top module: `test_ramp_gen`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `out_valid` is 0 and `out_data` is 0. The internal column and sliding offset also return to 0.
- R2: With `mode` at 2'b00 or at 2'b11 (live), a pixel accepted with `pix_en` high appears on `out_data` one cycle later, equal to that cycle's `sensor_data`.
- R3: With `mode` at 2'b01 (fixed), a pixel at column c produces code 960 + c. A pixel presented together with `line_start` is column 0, so a full line of 1312 pixels runs from 960 to 2271.
- R4: If no `line_start` arrives, the column that follows column 1311 is column 0 again.
- R5: In fixed mode `frame_start` has no effect. Every line carries the same ramp.
- R6: With `mode` at 2'b10 (sliding), each `frame_start` raises the ramp offset by 2, provided sliding mode was also selected in the previous cycle. The code is 960 + offset + c. A pixel in the same cycle as the strobe already uses the raised offset.
- R7: The offset is 0 whenever sliding mode is not selected. The cycle that enters sliding mode never raises it, even if `frame_start` is high in that cycle. The first frame in sliding mode is therefore the fixed ramp.
- R8: Generated codes wrap modulo 4096.
- R9: `out_valid` equals `pix_en` of the previous cycle. After a cycle with `pix_en` low, `out_data` keeps its previous value.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 live, 01 fixed ramp, 10 sliding ramp, 11 live |
| line_start | input | 1 | First pixel of a line is in this cycle |
| frame_start | input | 1 | First cycle of a new frame |
| pix_en | input | 1 | A pixel is presented in this cycle |
| sensor_data | input | 12 | Live pixel from the sensor |
| out_data | output | 12 | Selected pixel, registered |
| out_valid | output | 1 | `out_data` was updated by a pixel |

## Verification
The bench runs full 1312-pixel lines and continues past the last column. A counter that wrapped early or saturated would break the 2271 end code or the restart at 960. It enters sliding mode in the same cycle as a frame strobe. A design that raised the offset on entry would start the first sliding frame at 962 instead of 960. It then drives a thousand short frames so that the offset grows far enough for codes to cross 4095. A design that did not truncate to 12 bits, or clamped at full scale, would show codes other than 175 at the end of that line. Gaps in `pix_en` and frame strobes given in fixed mode check that idle cycles hold the output and that the fixed ramp never moves.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int unsigned TPG_PIX_W       = 12;
    localparam int unsigned TPG_LINE_PIXELS = 1312;
    localparam int unsigned TPG_RAMP_START  = 960;
    localparam int unsigned TPG_SLIDE_STEP  = 2;

    typedef enum logic [1:0] {
        TPG_LIVE     = 2'b00,
        TPG_FIXED    = 2'b01,
        TPG_SLIDE    = 2'b10,
        TPG_LIVE_ALT = 2'b11
    } tpg_mode_e;

    typedef struct packed {
        logic use_gen;
        logic slide;
    } tpg_sel_t;

    function automatic tpg_sel_t tpg_decode(input logic [1:0] m);
        tpg_sel_t s;
        unique case (tpg_mode_e'(m))
            TPG_FIXED: s = '{use_gen: 1'b1, slide: 1'b0};
            TPG_SLIDE: s = '{use_gen: 1'b1, slide: 1'b1};
            default:   s = '{use_gen: 1'b0, slide: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tpg_col_ctr.sv
module tpg_col_ctr #(
    parameter int unsigned LINE_PIXELS = tpg_pkg::TPG_LINE_PIXELS,
    localparam int unsigned COL_W      = $clog2(LINE_PIXELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             line_start,
    output logic [COL_W-1:0] col_cur
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_PIXELS - 1);

    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] col_d;

    always_comb begin
        col_cur = line_start ? '0 : col_q;
        if (pix_en)
            col_d = (col_cur == LAST_COL) ? '0 : col_cur + COL_W'(1);
        else
            col_d = col_cur;
    end

    always_ff @(posedge clk) begin
        if (rst) col_q <= '0;
        else     col_q <= col_d;
    end

    a_r4_col_in_range: assert property (@(posedge clk) disable iff (rst)
        col_q <= LAST_COL);

    a_r3_col_steps: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !line_start && col_q != LAST_COL) |=> col_q == $past(col_q) + COL_W'(1));

    a_r4_col_wraps: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !line_start && col_q == LAST_COL) |=> col_q == '0);

endmodule

// File: rtl/tpg_slide_off.sv
module tpg_slide_off #(
    parameter int unsigned PIX_W = tpg_pkg::TPG_PIX_W,
    parameter int unsigned STEP  = tpg_pkg::TPG_SLIDE_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slide_now,
    input  logic             frame_start,
    output logic [PIX_W-1:0] off_cur
);
    logic             slide_q;
    logic [PIX_W-1:0] off_q;
    logic             bump;

    assign bump = slide_now && slide_q && frame_start;

    always_comb begin
        if (!slide_now)  off_cur = '0;
        else if (bump)   off_cur = off_q + PIX_W'(STEP);
        else             off_cur = off_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slide_q <= 1'b0;
            off_q   <= '0;
        end else begin
            slide_q <= slide_now;
            off_q   <= off_cur;
        end
    end

    a_r7_off_cleared: assert property (@(posedge clk) disable iff (rst)
        !slide_now |=> off_q == '0);

    a_r7_entry_no_bump: assert property (@(posedge clk) disable iff (rst)
        (slide_now && !slide_q) |=> off_q == '0);

    a_r6_off_holds: assert property (@(posedge clk) disable iff (rst)
        (slide_now && slide_q && !frame_start) |=> $stable(off_q));

endmodule

// File: rtl/tpg_out_stage.sv
module tpg_out_stage #(
    parameter int unsigned PIX_W = tpg_pkg::TPG_PIX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             use_gen,
    input  logic [PIX_W-1:0] gen_code,
    input  logic [PIX_W-1:0] sensor_data,
    output logic [PIX_W-1:0] out_data,
    output logic             out_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= pix_en;
            if (pix_en)
                out_data <= use_gen ? gen_code : sensor_data;
        end
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> out_valid);

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> (!out_valid && $stable(out_data)));

    a_r2_live_pass: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !use_gen) |=> out_data == $past(sensor_data));

endmodule

// File: rtl/test_ramp_gen.sv
module test_ramp_gen #(
    parameter int unsigned PIX_W       = tpg_pkg::TPG_PIX_W,
    parameter int unsigned LINE_PIXELS = tpg_pkg::TPG_LINE_PIXELS,
    parameter int unsigned RAMP_START  = tpg_pkg::TPG_RAMP_START,
    parameter int unsigned SLIDE_STEP  = tpg_pkg::TPG_SLIDE_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             line_start,
    input  logic             frame_start,
    input  logic             pix_en,
    input  logic [PIX_W-1:0] sensor_data,
    output logic [PIX_W-1:0] out_data,
    output logic             out_valid
);
    import tpg_pkg::*;

    localparam int unsigned COL_W = $clog2(LINE_PIXELS);

    tpg_sel_t         sel;
    logic [COL_W-1:0] col_cur;
    logic [PIX_W-1:0] off_cur;
    logic [PIX_W-1:0] col_ext;
    logic [PIX_W-1:0] gen_code;

    assign sel = tpg_decode(mode);

    generate
        if (COL_W <= PIX_W) begin : g_col_fit
            assign col_ext = PIX_W'(col_cur);
        end else begin : g_col_trunc
            assign col_ext = col_cur[PIX_W-1:0];
        end
    endgenerate

    assign gen_code = PIX_W'(RAMP_START) + off_cur + col_ext;

    tpg_col_ctr #(.LINE_PIXELS(LINE_PIXELS)) u_col (
        .clk        (clk),
        .rst        (rst),
        .pix_en     (pix_en),
        .line_start (line_start),
        .col_cur    (col_cur)
    );

    tpg_slide_off #(.PIX_W(PIX_W), .STEP(SLIDE_STEP)) u_off (
        .clk         (clk),
        .rst         (rst),
        .slide_now   (sel.slide),
        .frame_start (frame_start),
        .off_cur     (off_cur)
    );

    tpg_out_stage #(.PIX_W(PIX_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .pix_en      (pix_en),
        .use_gen     (sel.use_gen),
        .gen_code    (gen_code),
        .sensor_data (sensor_data),
        .out_data    (out_data),
        .out_valid   (out_valid)
    );

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    a_r5_fixed_line_head: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && pix_en && line_start) |=> out_data == PIX_W'(RAMP_START));

endmodule

// File: tb/tb_test_ramp_gen.sv
module tb_test_ramp_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        line_start = 1'b0;
    logic        frame_start = 1'b0;
    logic        pix_en = 1'b0;
    logic [11:0] sensor_data = '0;
    logic [11:0] out_data;
    logic        out_valid;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit started = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_col = 0;
    int m_off = 0;
    int m_prev_mode = 0;
    int exp_data = 0;
    bit exp_valid = 1'b0;

    always #4 clk = ~clk;

    test_ramp_gen dut (
        .clk(clk), .rst(rst), .mode(mode), .line_start(line_start),
        .frame_start(frame_start), .pix_en(pix_en), .sensor_data(sensor_data),
        .out_data(out_data), .out_valid(out_valid)
    );

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            m_col = 0; m_off = 0; m_prev_mode = 0;
            exp_data = 0; exp_valid = 1'b0;
        end else begin
            int c;
            if (mode != 2) m_off = 0;
            else if (m_prev_mode == 2 && frame_start) m_off = (m_off + 2) % 4096;
            c = line_start ? 0 : m_col;
            exp_valid = pix_en;
            if (pix_en) begin
                if (mode == 1)      exp_data = (960 + c) % 4096;
                else if (mode == 2) exp_data = (960 + m_off + c) % 4096;
                else                exp_data = sensor_data;
                m_col = (c + 1) % 1312;
            end else begin
                m_col = c;
            end
            m_prev_mode = mode;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (out_valid !== exp_valid || out_data !== 12'(exp_data)) begin
                fails++;
                $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
                         cur_req, out_valid, out_data, exp_valid, exp_data);
            end
        end
    end

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic px(input bit ls, input bit fs, input bit pe, input int sd);
        @(negedge clk);
        line_start = ls; frame_start = fs; pix_en = pe; sensor_data = 12'(sd);
    endtask

    task automatic sample_after_edge(output int v);
        @(posedge clk); #1; v = out_data;
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v;
        repeat (3) px(0, 0, 0, 0);
        @(posedge clk); #1;
        chk(out_valid, 0, "R1"); chk(out_data, 0, "R1");
        px(0, 0, 0, 0);
        rst = 1'b0;

        cur_req = "R2";
        mode = 2'b00;
        for (int i = 0; i < 40; i++) px(i == 0, 0, (i % 5) != 3, i * 37 + 5);
        px(0, 0, 1, 12'hABC); sample_after_edge(v); chk(v, 12'hABC, "R2");
        @(negedge clk); mode = 2'b11;
        for (int i = 0; i < 30; i++) px(0, 0, 1, 4095 - i * 11);
        px(0, 0, 1, 12'h5A5); sample_after_edge(v); chk(v, 12'h5A5, "R2");

        cur_req = "R3";
        @(negedge clk); mode = 2'b01;
        px(1, 0, 1, 77); sample_after_edge(v); chk(v, 960, "R3");
        for (int i = 1; i < 1311; i++) px(0, 0, 1, i);
        px(0, 0, 1, 0); sample_after_edge(v); chk(v, 2271, "R3");
        cur_req = "R4";
        px(0, 0, 1, 0); sample_after_edge(v); chk(v, 960, "R4");
        for (int i = 0; i < 4; i++) px(0, 0, 1, 0);

        cur_req = "R5";
        px(0, 1, 0, 0);
        px(1, 1, 1, 0); sample_after_edge(v); chk(v, 960, "R5");
        for (int i = 1; i < 20; i++) px(0, i == 9, 1, 0);
        px(0, 0, 1, 0); sample_after_edge(v); chk(v, 980, "R5");

        cur_req = "R9";
        for (int i = 0; i < 12; i++) px(0, 0, i % 3 == 0, i);

        cur_req = "R7";
        @(negedge clk); mode = 2'b10;
        px(1, 0, 1, 0); sample_after_edge(v); chk(v, 960, "R7");
        for (int i = 0; i < 8; i++) px(0, 0, 1, 0);
        cur_req = "R6";
        px(0, 1, 0, 0);
        px(1, 0, 1, 0); sample_after_edge(v); chk(v, 962, "R6");
        for (int i = 0; i < 5; i++) px(0, 0, 1, 0);
        px(1, 1, 1, 0); sample_after_edge(v); chk(v, 964, "R6");
        for (int i = 0; i < 5; i++) px(0, 0, 1, 0);

        cur_req = "R7";
        @(negedge clk); mode = 2'b01;
        for (int i = 0; i < 4; i++) px(i == 0, 0, 1, 0);
        @(negedge clk);
        mode = 2'b10; line_start = 1; frame_start = 1; pix_en = 1;
        sample_after_edge(v); chk(v, 960, "R7");
        for (int i = 0; i < 6; i++) px(0, 0, 1, 0);

        cur_req = "R8";
        for (int f = 0; f < 1000; f++) begin
            px(0, 1, 0, 0);
            px(1, 0, 1, 0);
            px(0, 0, 0, 0);
        end
        px(1, 0, 1, 0); sample_after_edge(v); chk(v, 2960, "R8");
        for (int i = 1; i < 1311; i++) px(0, 0, 1, 0);
        px(0, 0, 1, 0); sample_after_edge(v); chk(v, 175, "R8");
        px(0, 0, 0, 0);
        @(negedge clk); mode = 2'b00;
        px(0, 0, 0, 0);
        px(0, 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule